// File: doc/BRIEF.md
# Shared-Adder Arithmetic Logic Unit with Set-Less-Than

This block is a purely combinational N-bit arithmetic logic unit, 32 bits wide by default. It takes two operands and a 3-bit function code. It returns a result word and a flag that is high when the result is all zeros. A datapath uses the flag to decide a branch-if-equal after a subtraction.

Bit 2 of the function code does two jobs. It selects the bitwise complement of the second operand, and it is the carry into one shared adder. That single adder therefore gives both the sum and the difference. The low two bits of the function code pick one of four sources: the bitwise AND, the bitwise OR, the adder output, or a one-bit less-than value. The AND and OR paths also see the complemented operand when bit 2 is set. The less-than value is the sign bit of the difference with zeros above it.

Top module: `slt_alu`

## Requirements
- R1: Function code 000 gives `y = a & b`.
- R2: Function code 001 gives `y = a | b`.
- R3: Function code 010 gives `y = a + b`, truncated to N bits; the carry out is dropped.
- R4: Function code 100 gives `y = a & ~b`.
- R5: Function code 101 gives `y = a | ~b`.
- R6: Function code 110 gives `y = a - b`, computed as `a + ~b + 1` and truncated to N bits.
- R7: Function code 111 gives a result whose bit 0 is bit N-1 of the truncated `a - b` and whose bits N-1..1 are zero. Signed overflow is not corrected: for example `a = 0x80000000, b = 1` gives 0.
- R8: Function code 011 drives `y` to all zeros, whatever the operands are.
- R9: `zero` is 1 exactly when all bits of `y` are 0, under every function code.
- R10: Both outputs are combinational functions of the present inputs, with no state and no clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | N (32) | First operand |
| b | input | N (32) | Second operand; complemented when bit 2 of `fn` is set |
| fn | input | 3 | Function code; bit 2 complements `b` and sets the carry in, bits 1:0 pick the result source |
| y | output | N (32) | Result word |
| zero | output | 1 | High when `y` is all zeros |

## Verification
The block holds no registers, so each result is due in the same cycle as the inputs that produce it. The bench changes the operands and the function code on a falling clock edge. It samples `y` and `zero` a short, fixed delay later, well before the next rising edge. Every check therefore sees outputs that have settled from the present inputs only. There is no latency to count, and no check depends on an earlier stimulus.

// File: rtl/slt_alu_pkg.sv
package slt_alu_pkg;

  // result source chosen by the low two function bits
  typedef enum logic [1:0] {
    SRC_AND = 2'b00,
    SRC_OR  = 2'b01,
    SRC_SUM = 2'b10,
    SRC_LT  = 2'b11
  } src_sel_e;

  // the one code with no operation behind it
  localparam logic [2:0] FN_VOID = 3'b011;

  function automatic src_sel_e src_of(input logic [2:0] fn);
    return src_sel_e'(fn[1:0]);
  endfunction

  function automatic logic inv_of(input logic [2:0] fn);
    return fn[2];
  endfunction

endpackage

// File: rtl/alu_operand_cond.sv
module alu_operand_cond #(
  parameter int W = 32
) (
  input  logic [W-1:0] b_in,
  input  logic         inv,
  output logic [W-1:0] b_out
);
  always_comb begin
    b_out = inv ? ~b_in : b_in;
  end
endmodule

// File: rtl/alu_chunk_adder.sv
module alu_chunk_adder #(
  parameter int W     = 32,
  parameter int CHUNK = 8
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         cin,
  output logic [W-1:0] sum
);
  localparam int NCH = W / CHUNK;

  // carry entering each chunk
  logic [NCH-1:0] c_in;

  assign c_in[0] = cin;

  for (genvar i = 0; i < NCH; i++) begin : g_chunk
    if (i < NCH - 1) begin : g_mid
      logic [CHUNK:0] part;
      always_comb begin
        part = {1'b0, op_a[i*CHUNK +: CHUNK]}
             + {1'b0, op_b[i*CHUNK +: CHUNK]}
             + {{CHUNK{1'b0}}, c_in[i]};
      end
      assign sum[i*CHUNK +: CHUNK] = part[CHUNK-1:0];
      assign c_in[i+1]             = part[CHUNK];
    end else begin : g_top
      // top chunk: carry out is not part of any result
      assign sum[i*CHUNK +: CHUNK] = op_a[i*CHUNK +: CHUNK]
                                   + op_b[i*CHUNK +: CHUNK]
                                   + {{(CHUNK-1){1'b0}}, c_in[i]};
    end
  end
endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
  parameter int W     = 32,
  parameter int GROUP = 8
) (
  input  logic [W-1:0] word,
  output logic         is_zero
);
  localparam int NG = W / GROUP;

  logic [NG-1:0] grp_any;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    assign grp_any[g] = |word[g*GROUP +: GROUP];
  end

  assign is_zero = ~|grp_any;
endmodule

// File: rtl/slt_alu.sv
module slt_alu
  import slt_alu_pkg::*;
#(
  parameter int N     = 32,
  parameter int CHUNK = 8,
  parameter int GROUP = 8
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic [2:0]   fn,
  output logic [N-1:0] y,
  output logic         zero
);
  localparam int TOP = N - 1;

  logic [N-1:0] b_cond;
  logic [N-1:0] sum;
  logic [N-1:0] y_mux;
  logic         inv;
  src_sel_e     src;

  assign inv = inv_of(fn);
  assign src = src_of(fn);

  alu_operand_cond #(.W(N)) u_cond (
    .b_in  (b),
    .inv   (inv),
    .b_out (b_cond)
  );

  alu_chunk_adder #(.W(N), .CHUNK(CHUNK)) u_add (
    .op_a (a),
    .op_b (b_cond),
    .cin  (inv),
    .sum  (sum)
  );

  always_comb begin
    y_mux = '0;
    if (fn != FN_VOID) begin
      unique case (src)
        SRC_AND: y_mux = a & b_cond;
        SRC_OR:  y_mux = a | b_cond;
        SRC_SUM: y_mux = sum;
        SRC_LT:  y_mux = {{TOP{1'b0}}, sum[TOP]};
        default: y_mux = '0;
      endcase
    end
  end

  assign y = y_mux;

  alu_zero_detect #(.W(N), .GROUP(GROUP)) u_zero (
    .word    (y_mux),
    .is_zero (zero)
  );

  always_comb begin
    if (!$isunknown({a, b, fn})) begin
      // R9
      zero_flag_chk: assert (zero == (y == '0))
        else $error("zero flag disagrees with result");
      // R7
      if (fn == 3'b111) begin
        lt_width_chk: assert (y[N-1:1] == '0)
          else $error("less-than result has upper bits set");
      end
      // R8
      if (fn == FN_VOID) begin
        void_code_chk: assert (zero)
          else $error("unused code produced a nonzero result");
      end
      // R3 R6
      if (fn[1:0] == 2'b10) begin
        arith_chk: assert (y == (fn[2] ? (a - b) : (a + b)))
          else $error("shared adder result wrong");
      end
    end
  end
endmodule

// File: tb/slt_alu_tb.sv
module slt_alu_tb;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic [N-1:0] a = '0;
  logic [N-1:0] b = '0;
  logic [2:0]   fn = 3'b000;
  logic [N-1:0] y;
  logic         zero;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  slt_alu #(.N(N)) u_dut (
    .a    (a),
    .b    (b),
    .fn   (fn),
    .y    (y),
    .zero (zero)
  );

  function automatic logic [N-1:0] ref_y(input logic [N-1:0] ra,
                                         input logic [N-1:0] rb,
                                         input logic [2:0]   rf);
    logic [N-1:0] d;
    d = ra - rb;
    case (rf)
      3'b000:  return ra & rb;
      3'b001:  return ra | rb;
      3'b010:  return ra + rb;
      3'b100:  return ra & ~rb;
      3'b101:  return ra | ~rb;
      3'b110:  return d;
      3'b111:  return {{(N-1){1'b0}}, d[N-1]};
      default: return '0;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] rf);
    case (rf)
      3'b000:  return "R1";
      3'b001:  return "R2";
      3'b010:  return "R3";
      3'b100:  return "R4";
      3'b101:  return "R5";
      3'b110:  return "R6";
      3'b111:  return "R7";
      default: return "R8";
    endcase
  endfunction

  // drive on falling edge, sample 2 ns later (R10: same-cycle result)
  task automatic apply(input logic [N-1:0] ta, input logic [N-1:0] tb_,
                       input logic [2:0] tf);
    logic [N-1:0] exp_y;
    @(negedge clk);
    a  = ta;
    b  = tb_;
    fn = tf;
    #2;
    exp_y = ref_y(ta, tb_, tf);
    total++;
    if (y !== exp_y) begin
      bad++;
      $display("FAIL %s R10 fn=%b a=%h b=%h y=%h expected %h",
               req_of(tf), tf, ta, tb_, y, exp_y);
    end
    total++;
    if (zero !== (exp_y == '0)) begin
      bad++;
      $display("FAIL R9 fn=%b a=%h b=%h zero=%b expected %b",
               tf, ta, tb_, zero, (exp_y == '0));
    end
  endtask

  initial begin
    fork
      begin
        void'($urandom(32'd1234));
        // directed: each code, plain values (R1 R2 R3 R4 R5 R6)
        for (int f = 0; f < 8; f++) begin
          apply(32'hF0F0_1234, 32'h0FF0_5678, 3'(f));
        end
        // R8: unused code with all-ones operands still yields 0
        apply('1, '1, 3'b011);
        // R6 R9: equal operands subtract to zero
        apply(32'hDEAD_BEEF, 32'hDEAD_BEEF, 3'b110);
        // R3: carry out dropped
        apply(32'hFFFF_FFFF, 32'h0000_0001, 3'b010);
        // R7: overflow ignored, sign bit of wrapped difference
        apply(32'h8000_0000, 32'h0000_0001, 3'b111);
        apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b111);
        apply(32'hFFFF_FFFF, 32'h0000_0000, 3'b111);
        apply(32'h0000_0005, 32'h0000_0005, 3'b111);
        // R4 R5: complement paths
        apply(32'h0000_0000, 32'h0000_0000, 3'b101);
        apply('1, '1, 3'b100);
        // random mix
        for (int i = 0; i < 3000; i++) begin
          logic [N-1:0] ra, rb;
          ra = $urandom();
          rb = (i % 7 == 0) ? ra : $urandom();
          apply(ra, rb, 3'($urandom_range(0, 7)));
        end
        done = 1;
      end
      begin
        repeat (100000) @(posedge clk);
        if (!done) begin
          total++;
          bad++;
          $display("FAIL watchdog expired");
        end
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule